// File: doc/BRIEF.md
# Clock Failure Monitor with Switchover

This block chooses whether the system runs from the on-chip oscillator or from an external crystal oscillator, and it watches the external clock for a stall. Software drives a source request, one enable bit per oscillator, a monitor enable, an interrupt enable and a write-one-to-clear strobe for the failure flag. The oscillators sit outside the block. Each one receives an enable and returns a ready signal. The clock multiplexer is modelled as a registered source select, `sys_src`.

A source change takes effect only after the oscillator being switched to reports ready. While monitoring is on, the raw external clock passes through a synchronizer and an edge detector into the internal-clock domain. If no edge arrives for a programmable number of internal cycles, the block declares a failure. It then shuts the external oscillator off and latches a sticky flag. If the interrupt enable is set, it raises a non-maskable interrupt request. If the external clock was driving the system, the block also forces the select back to the internal clock. That forced state stays until software re-enables the external oscillator and then requests it again.

Top module: `cfm_top`

## Requirements
- R1: A change of `sys_src` (0 = internal, 1 = external) happens only after the ready input of the requested source is high. It appears on the clock edge after that ready is seen. Without ready, the old source stays.
- R2: `int_osc_on` is high whenever `mon_en` is high, `int_en_bit` is high, the internal clock is active, or the internal clock is the effective request.
- R3: `ext_osc_on` is high whenever `ext_en_bit` is high, the external clock is active, or the external clock is the effective request. A detected failure overrides all of these.
- R4: With `mon_en` high, an external clock with no transition for TIMEOUT (default 32) internal cycles sets `stuck_flag`. A running external clock never sets it. With `mon_en` low, the flag is never set.
- R5: On a failure, `ext_osc_on` drops on the edge that sets the flag. It stays low until `ext_en_bit` goes from 0 to 1.
- R6: `stuck_flag` stays set until a cycle with `flag_clr` high. A new failure in that same cycle wins over the clear.
- R7: `nmi_req` is high exactly when `stuck_flag` is high and `irq_en` is high.
- R8: A failure while the external clock is active forces `sys_src` to internal and sets `fallback_active`. This holds, whatever `sel_req` and `ext_rdy` do, until the external oscillator has been re-enabled (R5) and `sel_req` then goes from 0 to 1.
- R9: A failure while the internal clock is active leaves `sys_src` internal and `fallback_active` low.
- R10: After reset, `sys_src` is internal and `stuck_flag`, `nmi_req`, `fallback_active` and `ext_osc_on` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock; all logic runs on it |
| srst | input | 1 | Synchronous active-high reset |
| sel_req | input | 1 | Requested system source, 0 internal, 1 external |
| int_en_bit | input | 1 | Software enable for the internal oscillator |
| ext_en_bit | input | 1 | Software enable for the external oscillator |
| mon_en | input | 1 | Enables external clock monitoring |
| irq_en | input | 1 | Enables the failure interrupt request |
| flag_clr | input | 1 | Write-one-to-clear strobe for the failure flag |
| int_rdy | input | 1 | Internal oscillator ready |
| ext_rdy | input | 1 | External oscillator ready |
| ext_clk_in | input | 1 | Raw external clock, sampled as data |
| int_osc_on | output | 1 | Enable to the internal oscillator |
| ext_osc_on | output | 1 | Enable to the external oscillator |
| sys_src | output | 1 | Active system source, 0 internal, 1 external |
| stuck_flag | output | 1 | Sticky external clock failure flag |
| nmi_req | output | 1 | Non-maskable interrupt request |
| fallback_active | output | 1 | Hardware-forced internal clock in effect |

## Verification
On every cycle, the assertions check four things:
- A switch to the external clock follows a ready.
- The oscillator enables are present while a source is active or monitored.
- A failure kills the external oscillator and, when that clock was active, forces the internal one.
- The flag is sticky and the interrupt gating holds.

Only the bench's scenarios can show three other behaviours:
- The timeout length.
- That a running external clock never trips the detector.
- The full recovery sequence: flag clear, oscillator re-enable and reselect, which depends on the order of software actions.

// File: rtl/cfm_pkg.sv
package cfm_pkg;

    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } clk_src_e;

    typedef struct packed {
        logic stuck;     // sticky failure flag
        logic ext_kill;  // external oscillator forced off
        logic fallback;  // system clock forced to internal
    } fail_state_t;

    function automatic logic src_ready(clk_src_e s, logic int_rdy, logic ext_rdy);
        return (s == SRC_EXT) ? ext_rdy : int_rdy;
    endfunction

    function automatic clk_src_e target_src(clk_src_e req, logic fallback);
        return fallback ? SRC_INT : req;
    endfunction

endpackage

// File: rtl/cfm_edge_sync.sv
module cfm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic srst,
    input  logic din,
    output logic edge_o
);
    logic [STAGES-1:0] q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (srst) q <= '0;
                else      q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (srst) q <= '0;
                else      q <= {q[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (srst) last_q <= 1'b0;
        else      last_q <= q[STAGES-1];
    end

    // any transition of the synchronized level counts as activity
    assign edge_o = q[STAGES-1] ^ last_q;
endmodule

// File: rtl/cfm_stuck_timer.sv
module cfm_stuck_timer #(
    parameter int TIMEOUT = 32
) (
    input  logic clk,
    input  logic srst,
    input  logic arm,
    input  logic edge_i,
    output logic fail_o
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt;

    // fail fires on the TIMEOUT-th consecutive cycle without an edge
    assign fail_o = arm && !edge_i && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (srst || !arm || edge_i || fail_o) cnt <= '0;
        else                                  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cfm_src_switch.sv
module cfm_src_switch
    import cfm_pkg::*;
(
    input  logic     clk,
    input  logic     srst,
    input  clk_src_e target,
    input  logic     force_int,
    input  logic     int_rdy,
    input  logic     ext_rdy,
    output clk_src_e active
);
    always_ff @(posedge clk) begin
        if (srst)
            active <= SRC_INT;
        else if (force_int)
            active <= SRC_INT;
        else if (target != active && src_ready(target, int_rdy, ext_rdy))
            active <= target;
    end
endmodule

// File: rtl/cfm_top.sv
module cfm_top
    import cfm_pkg::*;
#(
    parameter int TIMEOUT     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic srst,
    input  logic sel_req,
    input  logic int_en_bit,
    input  logic ext_en_bit,
    input  logic mon_en,
    input  logic irq_en,
    input  logic flag_clr,
    input  logic int_rdy,
    input  logic ext_rdy,
    input  logic ext_clk_in,
    output logic int_osc_on,
    output logic ext_osc_on,
    output logic sys_src,
    output logic stuck_flag,
    output logic nmi_req,
    output logic fallback_active
);
    fail_state_t fs;
    clk_src_e    req_src, tgt_src, act_src;
    logic        ext_edge, fail_now;
    logic        ext_en_q, sel_q;
    logic        ext_en_rise, sel_rise;

    assign req_src = clk_src_e'(sel_req);
    assign tgt_src = target_src(req_src, fs.fallback);

    cfm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .srst   (srst),
        .din    (ext_clk_in),
        .edge_o (ext_edge)
    );

    // the timer is parked while the external oscillator is held off
    cfm_stuck_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk    (clk),
        .srst   (srst),
        .arm    (mon_en && !fs.ext_kill),
        .edge_i (ext_edge),
        .fail_o (fail_now)
    );

    cfm_src_switch u_switch (
        .clk       (clk),
        .srst      (srst),
        .target    (tgt_src),
        .force_int (fail_now),
        .int_rdy   (int_rdy),
        .ext_rdy   (ext_rdy),
        .active    (act_src)
    );

    always_ff @(posedge clk) begin
        if (srst) begin
            ext_en_q <= 1'b0;
            sel_q    <= 1'b0;
        end else begin
            ext_en_q <= ext_en_bit;
            sel_q    <= sel_req;
        end
    end

    assign ext_en_rise = ext_en_bit && !ext_en_q;
    assign sel_rise    = sel_req && !sel_q;

    always_ff @(posedge clk) begin
        if (srst) begin
            fs <= '0;
        end else begin
            if (fail_now)      fs.stuck <= 1'b1;
            else if (flag_clr) fs.stuck <= 1'b0;

            if (fail_now)         fs.ext_kill <= 1'b1;
            else if (ext_en_rise) fs.ext_kill <= 1'b0;

            if (fail_now && act_src == SRC_EXT)          fs.fallback <= 1'b1;
            else if (fs.fallback && !fs.ext_kill && sel_rise) fs.fallback <= 1'b0;
        end
    end

    assign int_osc_on = mon_en || int_en_bit || (act_src == SRC_INT) || (tgt_src == SRC_INT);
    assign ext_osc_on = !fs.ext_kill &&
                        (ext_en_bit || (act_src == SRC_EXT) || (tgt_src == SRC_EXT));
    assign sys_src         = act_src;
    assign stuck_flag      = fs.stuck;
    assign nmi_req         = fs.stuck && irq_en;
    assign fallback_active = fs.fallback;
endmodule

// File: rtl/cfm_checker.sv
module cfm_checker (
    input logic clk,
    input logic srst,
    input logic sel_req,
    input logic int_en_bit,
    input logic ext_en_bit,
    input logic mon_en,
    input logic irq_en,
    input logic flag_clr,
    input logic int_rdy,
    input logic ext_rdy,
    input logic int_osc_on,
    input logic ext_osc_on,
    input logic sys_src,
    input logic stuck_flag,
    input logic nmi_req,
    input logic fallback_active
);
    assert_switch_ready_R1: assert property (@(posedge clk) disable iff (srst)
        $rose(sys_src) |-> $past(ext_rdy));

    assert_int_osc_on_R2: assert property (@(posedge clk) disable iff (srst)
        (mon_en || int_en_bit || !sys_src) |-> int_osc_on);

    assert_ext_osc_on_R3: assert property (@(posedge clk) disable iff (srst)
        sys_src |-> ext_osc_on);

    assert_flag_needs_monitor_R4: assert property (@(posedge clk) disable iff (srst)
        $rose(stuck_flag) |-> $past(mon_en));

    assert_fail_kills_ext_R5: assert property (@(posedge clk) disable iff (srst)
        $rose(stuck_flag) |-> !ext_osc_on);

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (srst)
        ($past(stuck_flag) && !$past(flag_clr)) |-> stuck_flag);

    assert_nmi_masked_R7: assert property (@(posedge clk) disable iff (srst)
        !irq_en |-> !nmi_req);

    assert_nmi_raised_R7: assert property (@(posedge clk) disable iff (srst)
        (stuck_flag && irq_en) |-> nmi_req);

    assert_fallback_switch_R8: assert property (@(posedge clk) disable iff (srst)
        ($rose(stuck_flag) && $past(sys_src)) |-> (!sys_src && fallback_active));

    assert_fallback_holds_R8: assert property (@(posedge clk) disable iff (srst)
        fallback_active |-> !sys_src);

    assert_ready_unused_R1: assert property (@(posedge clk) disable iff (srst)
        $fell(sys_src) |-> ($past(int_rdy) || $past(stuck_flag) || stuck_flag));

    assert_sel_seen_R1: assert property (@(posedge clk) disable iff (srst)
        $rose(sys_src) |-> $past(sel_req));
endmodule

bind cfm_top cfm_checker u_cfm_checker (
    .clk             (clk),
    .srst            (srst),
    .sel_req         (sel_req),
    .int_en_bit      (int_en_bit),
    .ext_en_bit      (ext_en_bit),
    .mon_en          (mon_en),
    .irq_en          (irq_en),
    .flag_clr        (flag_clr),
    .int_rdy         (int_rdy),
    .ext_rdy         (ext_rdy),
    .int_osc_on      (int_osc_on),
    .ext_osc_on      (ext_osc_on),
    .sys_src         (sys_src),
    .stuck_flag      (stuck_flag),
    .nmi_req         (nmi_req),
    .fallback_active (fallback_active)
);

// File: tb/tb_cfm_top.sv
module tb_cfm_top;
    localparam int CLK_PERIOD = 10;
    localparam int EXT_HALF   = 17;

    logic clk = 1'b0;
    logic srst = 1'b1;
    logic sel_req = 1'b0, int_en_bit = 1'b0, ext_en_bit = 1'b0;
    logic mon_en = 1'b0, irq_en = 1'b0, flag_clr = 1'b0;
    logic int_rdy = 1'b1, ext_rdy = 1'b0;
    logic ext_clk_in = 1'b0, ext_run = 1'b0;
    logic int_osc_on, ext_osc_on, sys_src, stuck_flag, nmi_req, fallback_active;

    int checks = 0;
    int errors = 0;

    cfm_top dut (
        .clk(clk), .srst(srst), .sel_req(sel_req), .int_en_bit(int_en_bit),
        .ext_en_bit(ext_en_bit), .mon_en(mon_en), .irq_en(irq_en),
        .flag_clr(flag_clr), .int_rdy(int_rdy), .ext_rdy(ext_rdy),
        .ext_clk_in(ext_clk_in), .int_osc_on(int_osc_on), .ext_osc_on(ext_osc_on),
        .sys_src(sys_src), .stuck_flag(stuck_flag), .nmi_req(nmi_req),
        .fallback_active(fallback_active)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always #(EXT_HALF) if (ext_run) ext_clk_in = ~ext_clk_in;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic t_reset;
        step(3);
        srst = 1'b0;
        step(1);
        check("R10 sys_src", sys_src, 1'b0);
        check("R10 stuck_flag", stuck_flag, 1'b0);
        check("R10 nmi_req", nmi_req, 1'b0);
        check("R10 fallback", fallback_active, 1'b0);
        check("R10 ext_osc_on", ext_osc_on, 1'b0);
        check("R2 int on while internal active", int_osc_on, 1'b1);
    endtask

    task automatic t_switch;
        ext_en_bit = 1'b1;
        sel_req    = 1'b1;
        step(5);
        check("R1 no switch without ready", sys_src, 1'b0);
        check("R3 ext on by enable", ext_osc_on, 1'b1);
        ext_rdy = 1'b1;
        step(1);
        check("R1 switch after ready", sys_src, 1'b1);
        check("R2 int off when unused", int_osc_on, 1'b0);
        mon_en = 1'b1;
        step(1);
        check("R2 int on by monitor", int_osc_on, 1'b1);
    endtask

    task automatic t_running_ok;
        ext_run = 1'b1;
        step(200);
        check("R4 running clock no flag", stuck_flag, 1'b0);
    endtask

    task automatic t_fail_ext;
        irq_en  = 1'b1;
        ext_run = 1'b0;
        step(25);
        check("R4 no flag before timeout", stuck_flag, 1'b0);
        step(25);
        check("R4 flag after timeout", stuck_flag, 1'b1);
        check("R5 ext oscillator off", ext_osc_on, 1'b0);
        check("R8 forced internal", sys_src, 1'b0);
        check("R8 fallback set", fallback_active, 1'b1);
        check("R7 nmi raised", nmi_req, 1'b1);
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
        step(1);
        check("R6 flag cleared", stuck_flag, 1'b0);
        check("R7 nmi follows flag", nmi_req, 1'b0);
        step(5);
        check("R8 holds despite ready", sys_src, 1'b0);
        check("R5 ext stays off", ext_osc_on, 1'b0);
    endtask

    task automatic t_recover;
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
        ext_run = 1'b1;
        ext_en_bit = 1'b0;
        sel_req = 1'b0;
        step(1);
        ext_en_bit = 1'b1;
        step(2);
        check("R5 re-enable restores ext", ext_osc_on, 1'b1);
        check("R8 still internal before reselect", sys_src, 1'b0);
        sel_req = 1'b1;
        step(3);
        check("R8 reselect returns to external", sys_src, 1'b1);
        check("R8 fallback released", fallback_active, 1'b0);
    endtask

    task automatic t_irq_masked;
        irq_en  = 1'b0;
        ext_run = 1'b0;
        step(50);
        check("R4 flag set when masked", stuck_flag, 1'b1);
        check("R7 nmi masked", nmi_req, 1'b0);
        irq_en = 1'b1;
        step(1);
        check("R7 nmi after unmask", nmi_req, 1'b1);
    endtask

    task automatic t_fail_int;
        t_recover();
        sel_req = 1'b0;
        step(2);
        check("R1 switch back to internal", sys_src, 1'b0);
        ext_run = 1'b0;
        step(50);
        check("R4 flag while internal", stuck_flag, 1'b1);
        check("R9 stays internal", sys_src, 1'b0);
        check("R9 no fallback", fallback_active, 1'b0);
        check("R5 ext off", ext_osc_on, 1'b0);
    endtask

    task automatic t_mon_off;
        flag_clr = 1'b1;
        mon_en   = 1'b0;
        step(1);
        flag_clr = 1'b0;
        ext_en_bit = 1'b0;
        step(1);
        ext_en_bit = 1'b1;
        step(100);
        check("R4 no flag when unmonitored", stuck_flag, 1'b0);
        check("R3 ext on by enable again", ext_osc_on, 1'b1);
    endtask

    initial begin
        t_reset();
        t_switch();
        t_running_ok();
        t_fail_ext();
        t_recover();
        t_irq_masked();
        t_fail_int();
        t_mon_off();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule